// File: doc/BRIEF.md
# Streaming Flat-Field Pixel Corrector

This block corrects each pixel of a video stream for its own dark level and its own sensitivity. Every input beat carries a raw 10-bit sample, a per-location dark offset and an 8-bit gain code, all qualified by one valid strobe. The offset is removed with a floor at zero. The remainder is scaled by an unsigned fixed-point gain that has one integer bit and seven fraction bits. The result is then limited to the full scale of the selected output width.

The block is a fixed three-stage pipeline with no back-pressure. Line-start and frame-start markers travel beside the data. The output-width mode and a bypass control are captured with every pixel, so they can change on any beat. Bypass returns the raw sample after the same delay, which lets a host compare raw and corrected frames without re-timing its downstream logic.

Top module: `flatfield_corrector`

## Requirements
- R1: While rst_n is low, out_valid, out_sol and out_sof are 0.
- R2: A beat accepted with in_valid high on clock edge k appears with out_valid high after edge k+2, i.e. three registers of latency. out_valid is low for every cycle that has no such beat.
- R3: When in_off is greater than or equal to the sample being corrected, the corrected value is 0.
- R4: Otherwise the corrected value is floor((sample - offset) * gain / 128), where gain is the unsigned code on in_gain.
- R5: Gain code 128 returns the clipped difference unchanged. Code 255 scales by 255/128, so a difference of 400 gives 796.
- R6: In 10-bit mode (cfg_mode8 = 0) any result of 1023 or more is output as 1023.
- R7: In 8-bit mode (cfg_mode8 = 1) the sample and the offset are each reduced to their upper 8 bits (bits 9:2) before correction. Results of 255 or more become 255. The value sits in out_pix[7:0], and out_pix[9:8] is 0.
- R8: With cfg_bypass = 1, out_pix equals in_pix with the same latency, whatever the offset, gain and mode.
- R9: out_sol and out_sof repeat in_sol and in_sof of the same beat. A marker raised while in_valid is low is ignored, and out_sol or out_sof never rises without out_valid.
- R10: cfg_mode8 and cfg_bypass are taken per beat. A change between two consecutive beats affects only the later beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bypass | input | 1 | Pass the raw sample through for this beat |
| cfg_mode8 | input | 1 | 8-bit output scale for this beat |
| in_valid | input | 1 | Input beat qualifier |
| in_sol | input | 1 | First pixel of a line |
| in_sof | input | 1 | First pixel of a frame |
| in_pix | input | 10 | Raw sample |
| in_off | input | 10 | Dark offset for this location |
| in_gain | input | 8 | Gain code, unsigned 1.7 |
| out_valid | output | 1 | Output beat qualifier |
| out_sol | output | 1 | Line-start marker, delayed |
| out_sof | output | 1 | Frame-start marker, delayed |
| out_pix | output | 10 | Corrected or bypassed sample |

## Verification
Saturation and a per-beat configuration change can land on the same beat. Clipping and saturation can also meet on neighbouring beats as they travel through the pipeline. The bench drives back-to-back beats in which a saturating pixel is immediately followed by one with a switched mode or with bypass set, and a clipped pixel is followed by a full-scale one. Each output beat is compared with a value that the bench derives from that beat's own stimulus. A configuration that leaks into the wrong pixel therefore shows up as a mismatch on exactly one beat.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

  typedef struct packed {
    logic bypass;
    logic mode8;
  } ffc_cfg_t;

  // difference floored at zero
  function automatic logic [31:0] ffc_clip_sub(logic [31:0] a, logic [31:0] b);
    return (a > b) ? (a - b) : 32'd0;
  endfunction

  // drop the fraction bits of a fixed-point product
  function automatic logic [31:0] ffc_drop_frac(logic [31:0] prod, int unsigned frac);
    return prod >> frac;
  endfunction

  // limit to a ceiling
  function automatic logic [31:0] ffc_limit(logic [31:0] v, logic [31:0] ceil_v);
    return (v >= ceil_v) ? ceil_v : v;
  endfunction

endpackage

// File: rtl/ffc_sub_stage.sv
module ffc_sub_stage
  import ffc_pkg::*;
#(
  parameter int PIX_W    = 10,
  parameter int NARROW_W = 8,
  parameter int GAIN_W   = 8
) (
  input  logic              clk,
  input  logic              ld,
  input  ffc_cfg_t          cfg_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [PIX_W-1:0]  off_i,
  input  logic [GAIN_W-1:0] gain_i,
  output ffc_cfg_t          cfg_o,
  output logic [PIX_W-1:0]  diff_o,
  output logic [PIX_W-1:0]  raw_o,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int DROP = PIX_W - NARROW_W;

  logic [PIX_W-1:0] pix_sel, off_sel, diff_n;

  always_comb begin
    if (cfg_i.mode8) begin
      pix_sel = pix_i >> DROP;
      off_sel = off_i >> DROP;
    end else begin
      pix_sel = pix_i;
      off_sel = off_i;
    end
    diff_n = PIX_W'(ffc_clip_sub(32'(pix_sel), 32'(off_sel)));
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      cfg_o  <= cfg_i;
      diff_o <= diff_n;
      raw_o  <= pix_i;
      gain_o <= gain_i;
    end
  end
endmodule

// File: rtl/ffc_mul_stage.sv
module ffc_mul_stage
  import ffc_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int GAIN_W = 8,
  localparam int PROD_W = PIX_W + GAIN_W
) (
  input  logic              clk,
  input  logic              ld,
  input  ffc_cfg_t          cfg_i,
  input  logic [PIX_W-1:0]  diff_i,
  input  logic [PIX_W-1:0]  raw_i,
  input  logic [GAIN_W-1:0] gain_i,
  output ffc_cfg_t          cfg_o,
  output logic [PROD_W-1:0] prod_o,
  output logic [PIX_W-1:0]  raw_o
);
  logic [PROD_W-1:0] prod_n;

  always_comb prod_n = PROD_W'(32'(diff_i) * 32'(gain_i));

  always_ff @(posedge clk) begin
    if (ld) begin
      cfg_o  <= cfg_i;
      prod_o <= prod_n;
      raw_o  <= raw_i;
    end
  end
endmodule

// File: rtl/ffc_sat_stage.sv
module ffc_sat_stage
  import ffc_pkg::*;
#(
  parameter int PIX_W    = 10,
  parameter int NARROW_W = 8,
  parameter int GAIN_W   = 8,
  localparam int PROD_W  = PIX_W + GAIN_W,
  localparam int FRAC_W  = GAIN_W - 1
) (
  input  logic              clk,
  input  logic              ld,
  input  ffc_cfg_t          cfg_i,
  input  logic [PROD_W-1:0] prod_i,
  input  logic [PIX_W-1:0]  raw_i,
  output logic [PIX_W-1:0]  pix_o
);
  localparam logic [31:0] FS_WIDE   = 32'((64'd1 << PIX_W) - 64'd1);
  localparam logic [31:0] FS_NARROW = 32'((64'd1 << NARROW_W) - 64'd1);

  logic [31:0]      scaled, limited;
  logic [PIX_W-1:0] pix_n;

  always_comb begin
    scaled  = ffc_drop_frac(32'(prod_i), FRAC_W);
    limited = ffc_limit(scaled, cfg_i.mode8 ? FS_NARROW : FS_WIDE);
    pix_n   = cfg_i.bypass ? raw_i : PIX_W'(limited);
  end

  always_ff @(posedge clk) begin
    if (ld) pix_o <= pix_n;
  end
endmodule

// File: rtl/ffc_mark_pipe.sv
module ffc_mark_pipe #(
  parameter int DEPTH = 3,
  parameter int MK_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MK_W-1:0] mk_i,
  output logic [MK_W-1:0] mk_o,
  output logic [DEPTH-1:0] vld_tap
);
  logic [MK_W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[i] <= '0;
      else if (i == 0) stg[i] <= mk_i;
      else             stg[i] <= stg[i-1];
    end
    assign vld_tap[i] = stg[i][0];
  end

  assign mk_o = stg[DEPTH-1];
endmodule

// File: rtl/flatfield_corrector.sv
module flatfield_corrector
  import ffc_pkg::*;
#(
  parameter int PIX_W    = 10,
  parameter int NARROW_W = 8,
  parameter int GAIN_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bypass,
  input  logic              cfg_mode8,
  input  logic              in_valid,
  input  logic              in_sol,
  input  logic              in_sof,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic [PIX_W-1:0]  in_off,
  input  logic [GAIN_W-1:0] in_gain,
  output logic              out_valid,
  output logic              out_sol,
  output logic              out_sof,
  output logic [PIX_W-1:0]  out_pix
);
  localparam int PROD_W = PIX_W + GAIN_W;
  localparam int LAT    = 3;

  ffc_cfg_t          cfg_in, s1_cfg, s2_cfg;
  logic [PIX_W-1:0]  s1_diff, s1_raw, s2_raw;
  logic [GAIN_W-1:0] s1_gain;
  logic [PROD_W-1:0] s2_prod;
  logic [2:0]        mk_in, mk_out;
  logic [LAT-1:0]    stage_vld;

  assign cfg_in = '{bypass: cfg_bypass, mode8: cfg_mode8};
  assign mk_in  = {in_valid & in_sof, in_valid & in_sol, in_valid};

  ffc_mark_pipe #(.DEPTH(LAT), .MK_W(3)) u_mark (
    .clk(clk), .rst_n(rst_n), .mk_i(mk_in), .mk_o(mk_out), .vld_tap(stage_vld)
  );

  ffc_sub_stage #(.PIX_W(PIX_W), .NARROW_W(NARROW_W), .GAIN_W(GAIN_W)) u_sub (
    .clk(clk), .ld(in_valid), .cfg_i(cfg_in), .pix_i(in_pix), .off_i(in_off),
    .gain_i(in_gain), .cfg_o(s1_cfg), .diff_o(s1_diff), .raw_o(s1_raw), .gain_o(s1_gain)
  );

  ffc_mul_stage #(.PIX_W(PIX_W), .GAIN_W(GAIN_W)) u_mul (
    .clk(clk), .ld(stage_vld[0]), .cfg_i(s1_cfg), .diff_i(s1_diff), .raw_i(s1_raw),
    .gain_i(s1_gain), .cfg_o(s2_cfg), .prod_o(s2_prod), .raw_o(s2_raw)
  );

  ffc_sat_stage #(.PIX_W(PIX_W), .NARROW_W(NARROW_W), .GAIN_W(GAIN_W)) u_sat (
    .clk(clk), .ld(stage_vld[1]), .cfg_i(s2_cfg), .prod_i(s2_prod), .raw_i(s2_raw),
    .pix_o(out_pix)
  );

  assign out_valid = mk_out[0];
  assign out_sol   = mk_out[1];
  assign out_sof   = mk_out[2];
endmodule

// File: rtl/ffc_checker.sv
module ffc_checker #(
  parameter int PIX_W    = 10,
  parameter int NARROW_W = 8,
  parameter int GAIN_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_bypass,
  input logic              cfg_mode8,
  input logic              in_valid,
  input logic [PIX_W-1:0]  in_pix,
  input logic [PIX_W-1:0]  in_off,
  input logic [GAIN_W-1:0] in_gain,
  input logic              out_valid,
  input logic              out_sol,
  input logic              out_sof,
  input logic [PIX_W-1:0]  out_pix,
  input logic [PIX_W-1:0]  s1_diff
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << (GAIN_W - 1));

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  logic warm1, warm3;
  assign warm1 = (age != 2'd0);
  assign warm3 = (age == 2'd3);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!out_valid && !out_sol && !out_sof); // R1
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    warm3 |-> (out_valid == $past(in_valid, 3))); // R2

  AST_CLIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_mode8 && (in_off >= in_pix)) |=> (s1_diff == '0)); // R3

  AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (warm3 && out_valid && !$past(cfg_bypass, 3) && !$past(cfg_mode8, 3) &&
     ($past(in_gain, 3) == UNITY) && ($past(in_off, 3) == '0))
    |-> (out_pix == $past(in_pix, 3))); // R5

  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm3 && out_valid && $past(cfg_mode8, 3) && !$past(cfg_bypass, 3))
    |-> (out_pix[PIX_W-1:NARROW_W] == '0)); // R7

  AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (warm3 && out_valid && $past(cfg_bypass, 3)) |-> (out_pix == $past(in_pix, 3))); // R8

  AST_MARK_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sol || out_sof) |-> out_valid); // R9

  logic unused_warm1;
  assign unused_warm1 = warm1;
endmodule

bind flatfield_corrector ffc_checker #(
  .PIX_W(PIX_W), .NARROW_W(NARROW_W), .GAIN_W(GAIN_W)
) u_ffc_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_mode8(cfg_mode8),
  .in_valid(in_valid), .in_pix(in_pix), .in_off(in_off), .in_gain(in_gain),
  .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof), .out_pix(out_pix),
  .s1_diff(s1_diff)
);

// File: tb/tb_flatfield_corrector.sv
`timescale 1ns/1ps
module tb_flatfield_corrector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_bypass = 1'b0, cfg_mode8 = 1'b0;
  logic       in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
  logic [9:0] in_pix = '0, in_off = '0;
  logic [7:0] in_gain = '0;
  logic       out_valid, out_sol, out_sof;
  logic [9:0] out_pix;

  always #2.5 clk = ~clk;

  flatfield_corrector dut (
    .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_mode8(cfg_mode8),
    .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof), .in_pix(in_pix),
    .in_off(in_off), .in_gain(in_gain), .out_valid(out_valid), .out_sol(out_sol),
    .out_sof(out_sof), .out_pix(out_pix)
  );

  int n_chk = 0, n_bad = 0, t = 0;
  bit finished = 0;

  // expected-beat ring, four slots for a three-cycle delay
  bit    ev [4];
  bit    es [4];
  bit    ef [4];
  int    ep [4];
  string etag [4];

  function automatic int model_pix(int pix, int off, int gain, bit m8, bit byp);
    int p, o, d, v, fs;
    if (byp) return pix;
    p  = m8 ? pix / 4 : pix;
    o  = m8 ? off / 4 : off;
    d  = (p > o) ? p - o : 0;
    v  = (d * gain) / 128;
    fs = m8 ? 255 : 1023;
    return (v > fs) ? fs : v;
  endfunction

  function automatic string model_tag(int pix, int off, int gain, bit m8, bit byp);
    int p, o;
    if (byp) return "R8";
    if (m8)  return "R7";
    p = pix; o = off;
    if (o >= p) return "R3";
    if (((p - o) * gain) / 128 >= 1023) return "R6";
    return "R4";
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", tag, act, exp, t);
    end
  endtask

  task automatic step(bit v, bit sol, bit sof, int pix, int off, int gain,
                      bit m8, bit byp, string tag_over);
    int slot;
    @(negedge clk);
    slot = (t + 1) % 4;
    check("R2", int'(out_valid), int'(ev[slot]));
    check("R9", int'(out_sol), int'(es[slot]));
    check("R9", int'(out_sof), int'(ef[slot]));
    if (ev[slot]) check(etag[slot], int'(out_pix), ep[slot]);
    in_valid = v; in_sol = sol; in_sof = sof;
    in_pix = 10'(pix); in_off = 10'(off); in_gain = 8'(gain);
    cfg_mode8 = m8; cfg_bypass = byp;
    slot = t % 4;
    ev[slot] = v; es[slot] = v && sol; ef[slot] = v && sof;
    ep[slot] = model_pix(pix, off, gain, m8, byp);
    etag[slot] = (tag_over != "") ? tag_over : model_tag(pix, off, gain, m8, byp);
    t++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin ev[i] = 0; es[i] = 0; ef[i] = 0; ep[i] = 0; etag[i] = "R2"; end
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_sol), 0);
    check("R1", int'(out_sof), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    step(1, 1, 1, 500, 100, 128, 0, 0, "R5");   // unity gain -> 400
    step(1, 0, 0, 500, 100, 255, 0, 0, "R5");   // 400*255/128 = 796
    step(1, 0, 0, 100, 100, 200, 0, 0, "R3");   // equal -> 0
    step(1, 0, 0, 50, 900, 255, 0, 0, "R3");    // negative -> 0
    step(1, 0, 0, 1023, 0, 255, 0, 0, "R6");    // saturate 1023
    step(1, 0, 0, 1023, 0, 255, 1, 0, "R10");   // mode switch on the next beat -> 255
    step(1, 0, 0, 1023, 0, 255, 0, 1, "R10");   // bypass on the next beat -> 1023 raw
    step(1, 0, 0, 777, 3, 7, 0, 1, "R8");       // bypass ignores gain/offset
    step(1, 0, 0, 1000, 200, 128, 1, 0, "R7");  // (250-50) = 200
    step(1, 0, 0, 1020, 0, 200, 1, 0, "R7");    // 255*200/128 -> 255
    step(0, 1, 1, 300, 0, 128, 0, 0, "R9");     // markers without valid ignored
    step(1, 0, 1, 0, 0, 255, 0, 0, "R3");
    step(1, 1, 0, 1023, 1023, 255, 0, 0, "R3");
    step(1, 0, 0, 1000, 0, 255, 0, 0, "R6");
    idle(4);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit v, sl, sf, m8, byp;
      int pix, off, gain;
      v   = ($urandom % 4) != 0;
      sl  = ($urandom % 8) == 0;
      sf  = ($urandom % 16) == 0;
      m8  = ($urandom % 3) == 0;
      byp = ($urandom % 7) == 0;
      pix = $urandom % 1024;
      off = (($urandom % 4) == 0) ? $urandom % 1024 : $urandom % 64;
      gain = (($urandom % 5) == 0) ? 128 : $urandom % 256;
      step(v, sl, sf, pix, off, gain, m8, byp, "");
    end
    idle(4);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule